// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that owns four 12-bit configuration registers. A host sends 16-bit commands one bit per rising edge of the serial clock while a frame-active input is held high. Each command holds a direction flag, a 3-bit register select and a 12-bit payload. A write command loads the payload into the chosen register. A read command sends the chosen register back on a separate return line, which has its own output-enable flag.

All four registers are driven in parallel onto one flat output bus, so neighbouring logic can use the settings at all times. Frames may follow each other with the frame input held high. A frame that is cut short is discarded.

Top module: `serCtrlBank`

## Requirements
- R1: Commands are sampled most significant bit first on rising clock edges while frameAct is high, in the order: direction flag (1 = read, 0 = write), select bit 2, select bit 1, select bit 0, then payload bits 11 down to 0.
- R2: A complete write frame with select 0 to 3 loads the 12 payload bits into that register on the edge that samples the final bit. Register i appears on regsFlat[i*12 +: 12].
- R3: A write frame with select 4 to 7 changes no register.
- R4: In a read frame, retOe goes high and retData shows register bit 11 after the edge that follows the edge sampling select bit 0. One further bit follows per edge, down to bit 0. retOe stays high for exactly 12 cycles.
- R5: A read returns the register's contents at the time select bit 0 is sampled, including a value written by the frame just before it. A read frame changes no register.
- R6: A read frame with select 4 to 7 returns twelve zero bits with retOe high.
- R7: Outside the 12 return cycles of a read, retOe and retData are both low, including all through a write frame.
- R8: If frameAct drops before 16 bits have been sampled, the partial command is dropped with no register change. The next frame is decoded from its first bit.
- R9: rstN is an asynchronous active-low reset. It clears all registers to zero and drives retOe and retData low.
- R10: With frameAct held high, the bit sampled after the 16th bit of a frame is the direction flag of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; bits are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameAct | input | 1 | High while a command is being sent |
| serIn | input | 1 | Serial command data |
| retData | output | 1 | Serial read-back data |
| retOe | output | 1 | High while retData carries read-back bits |
| regsFlat | output | 48 | The four registers, register i at bits [i*12 +: 12] |

## Verification
With frames sent back to back, two events share a cycle. The last return bit of a read stays on retData during the cycle in which the direction flag of the next command is sampled. A write that completes is also followed at once by a read of the same register. The bench sends a read, then a write, then a read with no gap, all with frameAct held high. A scoreboard matches every cycle in which retOe is high against the queue of expected bits. This shows that the return line lets go at the right edge without taking a bit from the new frame, and that the read sees the value just committed.

// File: rtl/serRegPkg.sv
package serRegPkg;

  // Strobes sent from the sequencing logic to the datapath, valid for one edge
  typedef struct packed {
    logic shiftIn;   // sample serIn into the command shifter
    logic commit;    // write payload into the selected register
    logic loadRet;   // capture the selected register for read-back
    logic retShift;  // present the next read-back bit
  } ctrlStrobes_t;

endpackage

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DATA_W  = 12,
  parameter int NREGS   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameAct,
  input  logic [SEL_W+DATA_W-1:0]   cmdShift,
  output ctrlStrobes_t              st
);
  localparam int FRAME_W = 1 + SEL_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SEL_IDX  = CNT_W'(SEL_W);

  logic [CNT_W-1:0] bitCnt;
  logic             readPhase;
  logic             atSel, atLast, rwAtSel, rwAtLast;
  logic [SEL_W-1:0] selAtLast;

  always_comb begin
    atSel     = frameAct && (bitCnt == SEL_IDX);
    atLast    = frameAct && (bitCnt == LAST_IDX);
    // direction flag position depends on how many bits are already shifted in
    rwAtSel   = cmdShift[SEL_W-1];
    rwAtLast  = cmdShift[FRAME_W-2];
    selAtLast = cmdShift[FRAME_W-3 -: SEL_W];

    st.shiftIn  = frameAct;
    st.commit   = atLast && !rwAtLast && (int'(selAtLast) < NREGS);
    st.loadRet  = atSel && rwAtSel;
    st.retShift = frameAct && readPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      readPhase <= 1'b0;
    end else if (!frameAct) begin
      bitCnt    <= '0;
      readPhase <= 1'b0;
    end else begin
      bitCnt <= atLast ? '0 : bitCnt + CNT_W'(1);
      if (st.loadRet)  readPhase <= 1'b1;
      else if (atLast) readPhase <= 1'b0;
    end
  end

  // R5
  commit_not_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> !readPhase);

endmodule

// File: rtl/serRegPath.sv
module serRegPath
  import serRegPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DATA_W  = 12,
  parameter int NREGS   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      serIn,
  input  ctrlStrobes_t              st,
  output logic [SEL_W+DATA_W-1:0]   cmdShift,
  output logic [NREGS*DATA_W-1:0]   regsFlat,
  output logic                      retData,
  output logic                      retOe
);
  localparam int FRAME_W = 1 + SEL_W + DATA_W;

  logic [NREGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0]            retWord;
  logic [DATA_W-1:0]            readVal;
  logic [SEL_W-1:0]             selRd, selWr;
  logic [DATA_W-1:0]            payload;

  always_comb begin
    selRd   = {cmdShift[SEL_W-2:0], serIn};
    selWr   = cmdShift[FRAME_W-3 -: SEL_W];
    payload = {cmdShift[DATA_W-2:0], serIn};
    readVal = '0;
    for (int i = 0; i < NREGS; i++)
      if (int'(selRd) == i) readVal = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdShift <= '0;
    else if (st.shiftIn) cmdShift <= {cmdShift[FRAME_W-3:0], serIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regFile <= '0;
    else if (st.commit)
      for (int i = 0; i < NREGS; i++)
        if (int'(selWr) == i) regFile[i] <= payload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retWord <= '0;
      retData <= 1'b0;
      retOe   <= 1'b0;
    end else begin
      if (st.loadRet) retWord <= readVal;
      else if (st.retShift) retWord <= {retWord[DATA_W-2:0], 1'b0};
      retData <= st.retShift ? retWord[DATA_W-1] : 1'b0;
      retOe   <= st.retShift;
    end
  end

  assign regsFlat = regFile;

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(regsFlat));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retOe |-> !retData);

  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retOe) |-> $past(st.loadRet, 2));

endmodule

// File: rtl/serCtrlBank.sv
module serCtrlBank
  import serRegPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DATA_W  = 12,
  parameter int NREGS   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameAct,
  input  logic                    serIn,
  output logic                    retData,
  output logic                    retOe,
  output logic [NREGS*DATA_W-1:0] regsFlat
);
  ctrlStrobes_t                st;
  logic [SEL_W+DATA_W-1:0]     cmdShift;

  serRegCtrl #(.SEL_W(SEL_W), .DATA_W(DATA_W), .NREGS(NREGS)) uCtrl (
    .clk(clk), .rstN(rstN), .frameAct(frameAct), .cmdShift(cmdShift), .st(st)
  );

  serRegPath #(.SEL_W(SEL_W), .DATA_W(DATA_W), .NREGS(NREGS)) uPath (
    .clk(clk), .rstN(rstN), .serIn(serIn), .st(st), .cmdShift(cmdShift),
    .regsFlat(regsFlat), .retData(retData), .retOe(retOe)
  );

endmodule

// File: tb/tb_serCtrlBank.sv
`timescale 1ns/1ps
module tb_serCtrlBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameAct = 1'b0;
  logic serIn = 1'b0;
  logic retData, retOe;
  logic [47:0] regsFlat;

  int checks = 0;
  int errors = 0;
  bit expQ[$];
  logic [11:0] model [4];

  always #2.5 clk = ~clk;

  serCtrlBank dut (.clk(clk), .rstN(rstN), .frameAct(frameAct), .serIn(serIn),
                   .retData(retData), .retOe(retOe), .regsFlat(regsFlat));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 4; i++)
      chk(regsFlat[i*12 +: 12] == model[i], req, $sformatf("reg%0d", i),
          int'(regsFlat[i*12 +: 12]), int'(model[i]));
  endtask

  // Driver: pushes the expected return bits, then drives the frame
  task automatic sendFrame(input bit rw, input int sel, input logic [11:0] data,
                           input int nbits);
    logic [15:0] w;
    logic [11:0] expWord;
    bit quietOk;
    w = {rw, 3'(sel), data};
    quietOk = 1'b1;
    if (rw && nbits == 16) begin
      expWord = (sel < 4) ? model[sel] : 12'h000;
      for (int b = 11; b >= 0; b--) expQ.push_back(expWord[b]);
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (!rw && i >= 1 && (retOe || retData)) quietOk = 1'b0;
      if (rw && nbits == 16 && i == 4)
        chk(retOe == 1'b0, "R4", "oe before D11 edge", int'(retOe), 0);
      if (rw && nbits == 16 && i == 5)
        chk(retOe == 1'b1, "R4", "oe after D11 edge", int'(retOe), 1);
      frameAct = 1'b1;
      serIn = w[15-i];
    end
    if (!rw && nbits > 1) chk(quietOk, "R7", "return quiet during write", 0, 0);
    if (!rw && nbits == 16 && sel < 4) model[sel] = data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frameAct = 1'b0;
      serIn = 1'b0;
    end
  endtask

  // Monitor: every cycle with the return line enabled must match the queue
  always @(negedge clk) begin
    if (rstN && retOe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7", "unexpected retOe", 1, 0);
      end else begin
        bit e;
        e = expQ.pop_front();
        chk(retData == e, "R4", "return bit", int'(retData), int'(e));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 12'h000;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkRegs("R9");
    chk(retOe == 1'b0 && retData == 1'b0, "R9", "outputs in reset",
        int'({retOe, retData}), 0);
    rstN = 1'b1;
    idle(2);

    // R1 R2: write every register with a distinct value
    sendFrame(0, 0, 12'hA5C, 16); idle(1); checkRegs("R2");
    sendFrame(0, 1, 12'h3F0, 16); idle(1);
    sendFrame(0, 2, 12'hFFF, 16); idle(1);
    sendFrame(0, 3, 12'h001, 16); idle(1); checkRegs("R1");

    // R4 R10: reads back to back with frameAct held high
    sendFrame(1, 0, 12'h000, 16);
    sendFrame(1, 1, 12'hFFF, 16);
    sendFrame(1, 2, 12'h123, 16);
    sendFrame(1, 3, 12'h000, 16);
    idle(3);
    chk(expQ.size() == 0, "R10", "queue drained", expQ.size(), 0);
    checkRegs("R5");

    // R3: write to unused codes
    sendFrame(0, 5, 12'h777, 16); idle(1); checkRegs("R3");
    sendFrame(0, 7, 12'hBAD, 16); idle(1); checkRegs("R3");

    // R6: read unused code returns zeros
    sendFrame(1, 6, 12'hFFF, 16); idle(3);
    chk(expQ.size() == 0, "R6", "zero read drained", expQ.size(), 0);

    // R8: aborted write, then a full frame decodes from its first bit
    sendFrame(0, 1, 12'h5A5, 9); idle(1); checkRegs("R8");
    sendFrame(0, 1, 12'h5A5, 15); idle(2); checkRegs("R8");
    sendFrame(0, 1, 12'h0C3, 16); idle(1); checkRegs("R8");

    // R5 R10: write then read same register without a gap, then another write
    sendFrame(0, 2, 12'h9E1, 16);
    sendFrame(1, 2, 12'h000, 16);
    sendFrame(0, 3, 12'h64B, 16);
    sendFrame(1, 3, 12'h000, 16);
    idle(3);
    chk(expQ.size() == 0, "R5", "back-to-back drained", expQ.size(), 0);
    checkRegs("R10");

    // R9: asynchronous reset between frames
    @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    for (int i = 0; i < 4; i++) model[i] = 12'h000;
    checkRegs("R9");
    idle(2);
    rstN = 1'b1;
    idle(2);
    checkRegs("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule